// File: doc/BRIEF.md
# Transceiver Tx/Rx Reset Sequencer

This block brings a serial transceiver out of reset when its internal Tx and Rx buffers are bypassed and user logic must therefore drive the reset order itself. After the system reset is released, it fires a one-cycle Tx reset pulse. It then waits for the transceiver to report that the Tx side has finished resetting, and flags the Tx path as ready. Only then does it raise the Rx reset. It holds the Rx reset until the transceiver reports that the Rx side is done, then drops it and flags the Rx path as ready.

Both done indications arrive from the transceiver's own clock domain. Each one passes through a two-flop synchronizer, and a stage is completed by a fresh low-to-high transition of the synchronized level, not by the level alone. User logic waits on the two ready flags. A system reset at any time clears every output and starts the whole sequence again.

Top module: `xcvr_rst_seq`

## Requirements
- R1: While `sysRst` is sampled high, all four outputs are low on the following cycle. On the first clock edge at which `sysRst` is sampled low, `txRstOut` goes high for exactly one cycle.
- R2: Each done input is synchronized by two flip-flops. A done input driven high before clock edge e, after being low at the edge before, completes its waiting stage at edge e+2.
- R3: The Tx stage completes only on a low-to-high transition of the synchronized Tx done that is seen after the Tx pulse. `txReady` then rises and stays high until the next system reset.
- R4: `rxRstOut` rises on the same edge as `txReady`, never earlier, and stays high while the Rx stage waits.
- R5: The Rx stage completes on a low-to-high transition of the synchronized Rx done while `rxRstOut` is high. `rxRstOut` falls and `rxReady` rises on that same edge.
- R6: An Rx done that rose before the Rx stage began and stays high does not complete the Rx stage. The stage waits for it to fall and rise again.
- R7: `rxReady` is never high while `txReady` is low, and the Tx and Rx resets are never high together.
- R8: A system reset during any stage, including after completion, clears all outputs and restarts the sequence from the Tx pulse.
- R9: Once both stages have completed, later changes of either done input leave both ready flags high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| sysRst | input | 1 | Synchronous active-high system reset; restarts the sequence |
| txDoneIn | input | 1 | Tx reset-done indication from the transceiver (asynchronous) |
| rxDoneIn | input | 1 | Rx reset-done indication from the transceiver (asynchronous) |
| txRstOut | output | 1 | Tx reset to the transceiver, a one-cycle pulse |
| rxRstOut | output | 1 | Rx reset to the transceiver, held until Rx done |
| txReady | output | 1 | Tx path released for user logic |
| rxReady | output | 1 | Rx path released for user logic |

## Verification
The latency properties assume that a done input, once driven high, holds that level for at least three clocks. Under that assumption the level seen two edges before a ready flag rises is the one that caused it. The bench changes the done inputs only on falling clock edges and keeps every level for several cycles, including the stale-high Rx done and the Tx done that stays high through a reset. It also assumes that `sysRst` is high from time zero, so the reset-value property never sees uninitialised registers.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

  // sequencer phases, in the order they are visited
  typedef enum logic [1:0] {
    ST_KICK   = 2'd0,
    ST_TXWAIT = 2'd1,
    ST_RXWAIT = 2'd2,
    ST_LIVE   = 2'd3
  } seqState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic txPulse;
    logic txFinish;
    logic rxFinish;
  } seqStrobe_t;

  // datapath -> control events
  typedef struct packed {
    logic txRise;
    logic rxRise;
  } seqEvent_t;

  localparam int LANES = 2;
  localparam int LANE_TX = 0;
  localparam int LANE_RX = 1;

endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic sysRst,
  input  logic asyncIn,
  output logic riseOut
);
  localparam int TOP = STAGES - 1;

  logic [TOP:0] chain;
  logic         prevQ;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (sysRst) chain <= '0;
        else        chain <= asyncIn;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (sysRst) chain <= '0;
        else        chain <= {chain[TOP-1:0], asyncIn};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (sysRst) prevQ <= 1'b0;
    else        prevQ <= chain[TOP];
  end

  assign riseOut = chain[TOP] & ~prevQ;
endmodule

// File: rtl/rstseq_datapath.sv
module rstseq_datapath
  import rstseq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       sysRst,
  input  logic       txDoneIn,
  input  logic       rxDoneIn,
  input  seqStrobe_t strobe,
  output seqEvent_t  ev,
  output logic       txRstOut,
  output logic       rxRstOut,
  output logic       txReady,
  output logic       rxReady
);
  logic [LANES-1:0] doneRaw;
  logic [LANES-1:0] doneRise;

  assign doneRaw[LANE_TX] = txDoneIn;
  assign doneRaw[LANE_RX] = rxDoneIn;

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      rstseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .sysRst  (sysRst),
        .asyncIn (doneRaw[g]),
        .riseOut (doneRise[g])
      );
    end
  endgenerate

  assign ev.txRise = doneRise[LANE_TX];
  assign ev.rxRise = doneRise[LANE_RX];

  logic txRstQ, rxRstQ, txRdyQ, rxRdyQ;

  always_ff @(posedge clk) begin
    if (sysRst) begin
      txRstQ <= 1'b0;
      rxRstQ <= 1'b0;
      txRdyQ <= 1'b0;
      rxRdyQ <= 1'b0;
    end else begin
      txRstQ <= strobe.txPulse;
      if (strobe.txFinish) begin
        txRdyQ <= 1'b1;
        rxRstQ <= 1'b1;
      end
      if (strobe.rxFinish) begin
        rxRstQ <= 1'b0;
        rxRdyQ <= 1'b1;
      end
    end
  end

  assign txRstOut = txRstQ;
  assign rxRstOut = rxRstQ;
  assign txReady  = txRdyQ;
  assign rxReady  = rxRdyQ;
endmodule

// File: rtl/rstseq_ctrl.sv
module rstseq_ctrl
  import rstseq_pkg::*;
(
  input  logic       clk,
  input  logic       sysRst,
  input  seqEvent_t  ev,
  output seqStrobe_t strobe
);
  seqState_t stateQ, stateNxt;

  always_ff @(posedge clk) begin
    if (sysRst) stateQ <= ST_KICK;
    else        stateQ <= stateNxt;
  end

  always_comb begin
    stateNxt = stateQ;
    strobe   = '0;
    unique case (stateQ)
      ST_KICK: begin
        strobe.txPulse = 1'b1;
        stateNxt       = ST_TXWAIT;
      end
      ST_TXWAIT: begin
        if (ev.txRise) begin
          strobe.txFinish = 1'b1;
          stateNxt        = ST_RXWAIT;
        end
      end
      ST_RXWAIT: begin
        if (ev.rxRise) begin
          strobe.rxFinish = 1'b1;
          stateNxt        = ST_LIVE;
        end
      end
      ST_LIVE: stateNxt = ST_LIVE;
      default: stateNxt = ST_KICK;
    endcase
  end
endmodule

// File: rtl/xcvr_rst_seq.sv
module xcvr_rst_seq
  import rstseq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic sysRst,
  input  logic txDoneIn,
  input  logic rxDoneIn,
  output logic txRstOut,
  output logic rxRstOut,
  output logic txReady,
  output logic rxReady
);
  seqStrobe_t strobe;
  seqEvent_t  ev;

  rstseq_ctrl u_ctrl (
    .clk    (clk),
    .sysRst (sysRst),
    .ev     (ev),
    .strobe (strobe)
  );

  rstseq_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk      (clk),
    .sysRst   (sysRst),
    .txDoneIn (txDoneIn),
    .rxDoneIn (rxDoneIn),
    .strobe   (strobe),
    .ev       (ev),
    .txRstOut (txRstOut),
    .rxRstOut (rxRstOut),
    .txReady  (txReady),
    .rxReady  (rxReady)
  );
endmodule

// File: rtl/xcvr_rst_seq_chk.sv
module xcvr_rst_seq_chk (
  input logic clk,
  input logic sysRst,
  input logic txDoneIn,
  input logic rxDoneIn,
  input logic txRstOut,
  input logic rxRstOut,
  input logic txReady,
  input logic rxReady
);
  // R1 R8
  reset_clears_chk: assert property (@(posedge clk)
    sysRst |=> (!txRstOut && !rxRstOut && !txReady && !rxReady));

  // R1
  kick_after_release_chk: assert property (@(posedge clk) disable iff (sysRst)
    $fell(sysRst) |=> txRstOut);

  // R1
  tx_pulse_single_chk: assert property (@(posedge clk) disable iff (sysRst)
    txRstOut |=> !txRstOut);

  // R2
  tx_sync_latency_chk: assert property (@(posedge clk) disable iff (sysRst)
    $rose(txReady) |-> $past(txDoneIn, 2));

  // R2
  rx_sync_latency_chk: assert property (@(posedge clk) disable iff (sysRst)
    $rose(rxReady) |-> $past(rxDoneIn, 2));

  // R3
  tx_ready_sticky_chk: assert property (@(posedge clk) disable iff (sysRst)
    txReady |=> txReady);

  // R4
  rx_rst_after_tx_chk: assert property (@(posedge clk) disable iff (sysRst)
    $rose(rxRstOut) |-> $rose(txReady));

  // R5
  rx_release_chk: assert property (@(posedge clk) disable iff (sysRst)
    ($fell(rxRstOut) && !$past(sysRst)) |-> $rose(rxReady));

  // R7
  ready_order_chk: assert property (@(posedge clk) disable iff (sysRst)
    rxReady |-> txReady);

  // R7
  resets_exclusive_chk: assert property (@(posedge clk) disable iff (sysRst)
    !(txRstOut && rxRstOut));

  // R9
  rx_ready_sticky_chk: assert property (@(posedge clk) disable iff (sysRst)
    rxReady |=> rxReady);
endmodule

bind xcvr_rst_seq xcvr_rst_seq_chk u_chk (
  .clk      (clk),
  .sysRst   (sysRst),
  .txDoneIn (txDoneIn),
  .rxDoneIn (rxDoneIn),
  .txRstOut (txRstOut),
  .rxRstOut (rxRstOut),
  .txReady  (txReady),
  .rxReady  (rxReady)
);

// File: tb/xcvr_rst_seq_bench.sv
`timescale 1ns/1ps
module xcvr_rst_seq_bench;
  logic clk = 1'b0;
  logic sysRst = 1'b1;
  logic txDoneIn = 1'b0;
  logic rxDoneIn = 1'b0;
  logic txRstOut, rxRstOut, txReady, rxReady;

  always #2 clk = ~clk;  // 250 MHz

  xcvr_rst_seq u_xcvr_rst_seq (
    .clk(clk), .sysRst(sysRst), .txDoneIn(txDoneIn), .rxDoneIn(rxDoneIn),
    .txRstOut(txRstOut), .rxRstOut(rxRstOut), .txReady(txReady), .rxReady(rxReady)
  );

  int total = 0;
  int bad = 0;
  int r7Bad = 0;
  bit finished = 0;

  // behavioural reference
  int phase = 0;
  bit txHist[$] = '{0, 0, 0};
  bit rxHist[$] = '{0, 0, 0};
  bit eTxRst = 0, eRxRst = 0, eTxRdy = 0, eRxRdy = 0;

  always @(posedge clk) begin
    bit riseTx, riseRx;
    if (sysRst) begin
      phase = 0;
      txHist = '{0, 0, 0};
      rxHist = '{0, 0, 0};
      eTxRst = 0; eRxRst = 0; eTxRdy = 0; eRxRdy = 0;
    end else begin
      riseTx = txHist[1] && !txHist[2];
      riseRx = rxHist[1] && !rxHist[2];
      eTxRst = 0;
      case (phase)
        0: begin eTxRst = 1; phase = 1; end
        1: if (riseTx) begin eTxRdy = 1; eRxRst = 1; phase = 2; end
        2: if (riseRx) begin eRxRst = 0; eRxRdy = 1; phase = 3; end
        default: ;
      endcase
      txHist.push_front(txDoneIn); void'(txHist.pop_back());
      rxHist.push_front(rxDoneIn); void'(rxHist.pop_back());
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // compare against the reference on every clock, away from the edge
  always @(negedge clk) begin
    if (!finished) begin
      check(txRstOut == eTxRst, "R1", "txRstOut", txRstOut, eTxRst);
      check(txReady == eTxRdy, "R3", "txReady", txReady, eTxRdy);
      check(rxRstOut == eRxRst, "R4", "rxRstOut", rxRstOut, eRxRst);
      check(rxReady == eRxRdy, "R5", "rxReady", rxReady, eRxRdy);
      if ((rxReady && !txReady) || (txRstOut && rxRstOut)) r7Bad++;
    end
  end

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL R8 watchdog actual=%0d expected=%0d", 0, 1);
      summary();
    end
  end

  initial begin
    // scenario 1: ordinary bring-up
    waitCyc(4);
    check(!txRstOut && !rxRstOut && !txReady && !rxReady, "R1", "outputs in reset", txRstOut, 0);
    sysRst = 0;
    waitCyc(1);
    check(txRstOut == 1, "R1", "tx pulse high", txRstOut, 1);
    waitCyc(1);
    check(txRstOut == 0, "R1", "tx pulse width", txRstOut, 0);
    waitCyc(5);
    check(txReady == 0 && rxRstOut == 0, "R3", "tx waits for done", txReady, 0);
    txDoneIn = 1;
    waitCyc(2);
    check(txReady == 0, "R2", "tx not ready before sync", txReady, 0);
    waitCyc(1);
    check(txReady == 1, "R2", "tx ready after sync", txReady, 1);
    check(rxRstOut == 1, "R4", "rx reset with tx ready", rxRstOut, 1);
    waitCyc(6);
    check(rxRstOut == 1 && rxReady == 0, "R5", "rx held waiting", rxReady, 0);
    rxDoneIn = 1;
    waitCyc(3);
    check(rxReady == 1 && rxRstOut == 0, "R5", "rx released", rxReady, 1);
    // R9: toggle dones after completion
    txDoneIn = 0; rxDoneIn = 0;
    waitCyc(5);
    txDoneIn = 1; rxDoneIn = 1;
    waitCyc(5);
    check(txReady && rxReady && !txRstOut && !rxRstOut, "R9", "ready kept", rxReady, 1);

    // scenario 2: reset from the finished state, stale rx done
    txDoneIn = 0; rxDoneIn = 0;
    sysRst = 1;
    waitCyc(3);
    check(!txReady && !rxReady, "R8", "cleared from live", txReady, 0);
    sysRst = 0;
    waitCyc(1);
    check(txRstOut == 1, "R8", "restart pulse", txRstOut, 1);
    waitCyc(3);
    rxDoneIn = 1;
    waitCyc(4);
    txDoneIn = 1;
    waitCyc(3);
    check(txReady == 1 && rxRstOut == 1, "R3", "tx done second run", txReady, 1);
    waitCyc(10);
    check(rxReady == 0 && rxRstOut == 1, "R6", "stale rx done ignored", rxReady, 0);
    rxDoneIn = 0;
    waitCyc(4);
    rxDoneIn = 1;
    waitCyc(3);
    check(rxReady == 1, "R6", "fresh rx edge accepted", rxReady, 1);

    // scenario 3: reset in the middle of the Rx wait, tx done stays high
    sysRst = 1; rxDoneIn = 0; txDoneIn = 0;
    waitCyc(2);
    sysRst = 0;
    waitCyc(3);
    txDoneIn = 1;
    waitCyc(4);
    check(rxRstOut == 1 && rxReady == 0, "R4", "rx wait before reset", rxRstOut, 1);
    sysRst = 1;
    waitCyc(2);
    check(!rxRstOut && !txReady, "R8", "mid-rx reset clears", rxRstOut, 0);
    sysRst = 0;
    waitCyc(1);
    check(txRstOut == 1, "R8", "pulse after mid reset", txRstOut, 1);
    waitCyc(5);
    check(txReady == 1, "R3", "held tx done refills sync", txReady, 1);
    rxDoneIn = 1;
    waitCyc(4);
    check(rxReady == 1, "R5", "third run complete", rxReady, 1);

    waitCyc(4);
    check(r7Bad == 0, "R7", "order violations", r7Bad, 0);
    finished = 1;
    summary();
  end
endmodule